// File: doc/BRIEF.md
# Serial Word to Gated Bit-Clock Interface

This block sits behind an FSK demodulator and turns its asynchronous 1200 baud serial stream into three simple outputs: a data line, a gated bit clock that pulses only for the payload bits, and an active-low end-of-word strobe. It runs from a sample clock at sixteen times the line rate, with one input sample taken on every rising edge. From that clock it finds the start bit of each 10-bit frame (one start bit, eight data bits, one stop bit) and times the bit cells. The same timing serves both common 1200 baud FSK framings.

A downstream shift register needs no UART. It shifts the data line on each rising edge of the bit clock, and it takes the byte when the strobe goes low. The clock never pulses during the start or stop bit, so a plain 8-bit shift register always holds exactly one payload byte. A power-down input parks every output at its idle-high level and makes the block ignore the line. When power-down is released, the block waits for the line to go high before it accepts the next frame.

Top module: `fsk_word_clocker`

## Requirements
- R1: Out of reset, `dout` is 1, `dclk` is 0 and `drdy_n` is 1.
- R2: A low pulse on `rx_in` is dropped as a glitch if the line is back high on the 9th sample after the first low sample (sample index 8, counting the first low sample as index 0). A dropped pulse gives no `dclk` edge and no `drdy_n` pulse.
- R3: An accepted frame gives exactly 8 rising edges on `dclk`. No edge falls in the start bit cell.
- R4: The first low sample is index 0. Rising edge n of `dclk` (n = 0..7) becomes visible 25 + 16·n sample-clock cycles after that sample. This is one sample after the centre sample of data bit n.
- R5: At rising edge n of `dclk`, `dout` holds data bit n. Bits are taken in line order, so the first data bit is bit 0 of the byte. `dout` does not change in the cycle where `dclk` rises.
- R6: Each `dclk` high phase lasts exactly 8 sample-clock cycles, which is half a bit.
- R7: If the stop bit is high at its centre sample (index 152), `drdy_n` goes low from cycle 152 and stays low for 8 cycles. This gives one strobe per word, and `dclk` stays low while `drdy_n` is low.
- R8: If the stop bit is low at its centre, no `drdy_n` pulse is issued. While the line then stays low, no new frame starts.
- R9: While `pwr_down` is 1, `dout`, `dclk` and `drdy_n` are all 1 in the same cycle, and activity on `rx_in` has no effect.
- R10: After `pwr_down` returns to 0 and the line is high, the next frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16 times the baud rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | High parks the outputs and ignores the line |
| rx_in | input | 1 | Demodulated serial bit stream |
| dout | output | 1 | Data bit taken at the current cell centre |
| dclk | output | 1 | Gated bit clock, one pulse per data bit |
| drdy_n | output | 1 | Active-low end-of-word strobe |

## Verification
The embedded properties assume the following about the inputs:
- `rx_in` changes at most once per sample clock.
- Frames are at least ten bit cells apart from start edge to start edge.
- `pwr_down` is driven synchronously.

The stimulus meets all three. It drives the line only on falling clock edges, and it holds every bit cell for exactly sixteen samples. Random idle gaps are added only after the stop cell has finished. On this basis, the properties check four points:
- No clock is active while the strobe is low.
- The strobe follows only the stop state.
- The data line is settled when the clock rises.
- Power-down returns the receiver to idle.

// File: rtl/fsk_word_clocker.sv
module fsk_word_clocker #(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic rx_in,
  output logic dout,
  output logic dclk,
  output logic drdy_n
);
  localparam int HALF = OSR / 2;
  localparam int CW   = $clog2(OSR);
  localparam int BW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           state;
  logic          armed;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bit_idx;
  logic          dout_q;
  logic          dclk_q;
  logic          pend;
  logic [CW-1:0] rdy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      armed   <= 1'b0;
      cnt     <= '0;
      bit_idx <= '0;
      dout_q  <= 1'b1;
      dclk_q  <= 1'b0;
      pend    <= 1'b0;
      rdy_cnt <= '0;
    end else if (pwr_down) begin
      state   <= S_IDLE;
      armed   <= 1'b0;
      cnt     <= '0;
      bit_idx <= '0;
      dout_q  <= 1'b1;
      dclk_q  <= 1'b0;
      pend    <= 1'b0;
      rdy_cnt <= '0;
    end else begin
      pend <= 1'b0;
      if (pend) dclk_q <= 1'b1;
      else if (dclk_q && cnt == CW'(HALF)) dclk_q <= 1'b0;
      if (rdy_cnt != '0) rdy_cnt <= rdy_cnt - 1'b1;

      case (state)
        S_IDLE: begin
          if (rx_in) armed <= 1'b1;
          else if (armed) begin
            state <= S_START;
            cnt   <= CW'(1);
            armed <= 1'b0;
          end
        end
        S_START: begin
          if (cnt == CW'(HALF)) begin
            if (!rx_in) begin
              state   <= S_DATA;
              cnt     <= '0;
              bit_idx <= '0;
            end else begin
              state <= S_IDLE;
              armed <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (cnt == CW'(OSR - 1)) begin
            cnt    <= '0;
            dout_q <= rx_in;
            pend   <= 1'b1;
            if (bit_idx == BW'(DATA_BITS - 1)) state <= S_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == CW'(OSR - 1)) begin
            cnt   <= '0;
            state <= S_IDLE;
            armed <= rx_in;
            if (rx_in) rdy_cnt <= CW'(HALF);
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign dout   = pwr_down | dout_q;
  assign dclk   = pwr_down | dclk_q;
  assign drdy_n = pwr_down | (rdy_cnt == '0);

  // R3: start cell never carries a clock pulse
  assert_no_clock_in_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START) |-> !dclk_q);

  // R5: data settled before the clock edge
  assert_data_stable_at_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && !$past(pwr_down) && $rose(dclk)) |-> $stable(dout));

  // R7: no clock while the word strobe is active
  assert_quiet_clock_on_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!drdy_n) |-> !dclk_q);

  // R7: strobe starts only from the stop cell
  assert_ready_from_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drdy_n) && !$past(pwr_down)) |-> ($past(state) == S_STOP));

  // R9: power-down returns the receiver to idle
  assert_powerdown_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (state == S_IDLE && !dclk_q && rdy_cnt == '0));
endmodule

// File: tb/fsk_word_clocker_tb.sv
module fsk_word_clocker_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, pwr_down = 1'b0, rx_in = 1'b1;
  logic dout, dclk, drdy_n;

  fsk_word_clocker u_dut (.clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
                          .rx_in(rx_in), .dout(dout), .dclk(dclk), .drdy_n(drdy_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, t0 = -100000;
  int rises = 0, readys = 0, rise_at = 0, fall_at = 0;
  logic [7:0] cap = '0;
  logic prev_dclk = 1'b0, prev_rdy = 1'b1, track = 1'b0;

  function automatic int exp_rise(int n); return 25 + 16*n; endfunction
  function automatic int exp_ready(bit stop_hi); return stop_hi ? 1 : 0; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    if (pwr_down) track = 1'b0;
    else begin
      if (dclk && !prev_dclk) begin
        if (rises < 8) cap[rises] = dout;
        chk(cyc == t0 + exp_rise(rises), "R4 clock edge time", cyc - t0, exp_rise(rises));
        rises++;
        rise_at = cyc;
        track = 1'b1;
      end
      if (!dclk && prev_dclk && track) begin
        chk(cyc - rise_at == 8, "R6 clock high time", cyc - rise_at, 8);
        track = 1'b0;
      end
      if (!drdy_n && prev_rdy) begin
        readys++;
        fall_at = cyc;
        chk(cyc == t0 + 152, "R7 ready start", cyc - t0, 152);
      end
      if (drdy_n && !prev_rdy)
        chk(cyc - fall_at == 8, "R7 ready width", cyc - fall_at, 8);
    end
    prev_dclk = dclk;
    prev_rdy  = drdy_n;
  end

  task automatic idle(int n);
    rx_in = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [7:0] b, bit stop_hi);
    @(negedge clk);
    t0 = cyc + 1; rises = 0; readys = 0; cap = '0;
    rx_in = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_in = b[i];
      repeat (16) @(negedge clk);
    end
    rx_in = stop_hi;
    repeat (16) @(negedge clk);
    chk(rises == 8, "R3 clock count", rises, 8);
    chk(cap == b, "R5 captured byte", cap, b);
    chk(readys == exp_ready(stop_hi), stop_hi ? "R7 ready count" : "R8 ready count",
        readys, exp_ready(stop_hi));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..all actual=%0d expected=%0d", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int gap;
    bit ok;
    repeat (3) @(negedge clk);
    chk(dout == 1'b1, "R1 dout", dout, 1);
    chk(dclk == 1'b0, "R1 dclk", dclk, 0);
    chk(drdy_n == 1'b1, "R1 drdy_n", drdy_n, 1);
    rst_n = 1'b1;
    idle(5);

    send(8'hA5, 1'b1); idle(3);
    send(8'h00, 1'b1);
    send(8'hFF, 1'b1);
    idle(20);

    // R2 glitch
    rises = 0; readys = 0;
    rx_in = 1'b0; repeat (5) @(negedge clk);
    idle(200);
    chk(rises == 0, "R2 glitch clocks", rises, 0);
    chk(readys == 0, "R2 glitch ready", readys, 0);

    // R8 bad stop, line held low
    send(8'h3C, 1'b0);
    rises = 0; readys = 0;
    repeat (60) @(negedge clk);
    chk(rises == 0, "R8 held low clocks", rises, 0);
    chk(readys == 0, "R8 held low ready", readys, 0);
    idle(10);
    send(8'hC3, 1'b1);
    idle(10);

    // R9 power-down in the middle of a frame
    @(negedge clk);
    t0 = cyc + 1; rises = 0; readys = 0;
    rx_in = 1'b0;
    repeat (40) @(negedge clk);
    pwr_down = 1'b1;
    #1;
    chk(dout && dclk && drdy_n, "R9 parked outputs", {dout, dclk, drdy_n}, 7);
    ok = 1'b1;
    for (int i = 0; i < 150; i++) begin
      rx_in = $urandom % 2;
      @(negedge clk);
      if (!(dout && dclk && drdy_n)) ok = 1'b0;
    end
    chk(ok, "R9 outputs held high", ok, 1);
    rx_in = 1'b1;
    @(negedge clk);
    pwr_down = 1'b0;
    rises = 0; readys = 0;
    idle(30);
    chk(rises == 0, "R9 no leftover clocks", rises, 0);
    chk(readys == 0, "R9 no leftover ready", readys, 0);
    send(8'h96, 1'b1);
    chk(cap == 8'h96, "R10 reception resumes", cap, 8'h96);
    idle(5);

    // random frames
    void'($urandom(32'd2024));
    for (int k = 0; k < 24; k++) begin
      b   = 8'($urandom);
      gap = $urandom % 12;
      if ($urandom % 6 == 0) begin
        send(b, 1'b0);
        repeat (8) @(negedge clk);
        idle(gap + 1);
      end else begin
        send(b, 1'b1);
        idle(gap);
      end
    end
    idle(30);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule